// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits between six interrupt request sources and a small CPU core. Two sources are external pins (active low, each selectable as level or falling-edge sensitive). Four are request flags raised by on-chip peripherals: timer 0, timer 1, the serial port and timer 2. Each source has its own enable bit and its own priority bit (high or low). A global enable bit gates every source at once. The controller picks one winning request and presents it to the CPU as a pending flag and a fixed vector address. The vectors are spaced eight bytes apart from 0x0003 upward.

The CPU pulses `irqAck` once it has saved its program counter and jumped to the vector. It pulses `irqRet` when the service routine returns. The controller keeps one in-service bit per priority level. A low-level routine can therefore be interrupted by a high-level request, but never by a request of its own level. A high-level routine cannot be interrupted at all. An edge-latched external request is consumed by the acknowledge that serves it. A level request simply follows its pin.

Source index order is fixed and also sets the tie-break order within a level: 0 external A, 1 timer 0, 2 external B, 3 timer 1, 4 serial, 5 timer 2.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irqPending` is 0 and `inService` is 2'b00.
- R2: A source can win only when its `srcEn` bit and `globalEn` are both 1. With `globalEn` at 0, `irqPending` is 0 whatever the requests.
- R3: While `irqPending` is 1, `irqVector` equals 0x0003 + 8*i for the winning source index i (index order as listed above, so 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B).
- R4: If any enabled request has its `srcPrioHigh` bit set, the winner is taken from those high-level requests only.
- R5: Among the eligible requests of the chosen level, the lowest source index wins.
- R6: An `irqAck` pulse while `irqPending` is 1 sets the in-service bit of the winner's level in the next cycle (`inService[1]` for high, `inService[0]` for low). An `irqAck` while nothing is pending leaves `inService` unchanged.
- R7: While only `inService[0]` is set, only high-level requests can be pending. While `inService[1]` is set, nothing is pending.
- R8: An `irqRet` pulse clears `inService[1]` if it is set, and otherwise clears `inService[0]`.
- R9: With `extEdgeMode[k]` at 1, a high-to-low transition on `extReqN[k]` latches a request that stays after the pin returns high. The acknowledge that serves that source clears the latch.
- R10: With `extEdgeMode[k]` at 0, the external request is the inverted pin level and is not latched: once the pin is high again, it no longer requests.
- R11: When `irqAck` and `irqRet` are high in the same cycle, only the return takes effect: the acknowledge sets no in-service bit and clears no latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| globalEn | input | 1 | Global interrupt enable |
| srcEn | input | 6 | Per-source enable, bit i for source index i |
| srcPrioHigh | input | 6 | Per-source priority, 1 = high level |
| extReqN | input | 2 | External request pins, active low (bit 0 = source 0, bit 1 = source 2) |
| extEdgeMode | input | 2 | 1 = falling-edge latched, 0 = level sensitive, per external pin |
| periphReq | input | 4 | Peripheral request flags: bit 0 timer 0, bit 1 timer 1, bit 2 serial, bit 3 timer 2 |
| irqAck | input | 1 | One-cycle pulse: CPU has taken the pending interrupt |
| irqRet | input | 1 | One-cycle pulse: CPU returned from a service routine |
| irqPending | output | 1 | A request is presented to the CPU |
| irqVector | output | 16 | Vector address of the winning source |
| inService | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
The bench builds the block with its default six sources, a 16-bit vector, base 0x0003 and stride 8. This configuration is small enough for full sweeps. Every combination of the six request bits is crossed with every priority mask, and again with every enable mask. This covers each level choice and tie-break outcome, and each gating case. Directed sequences then walk the nesting rules through the in-service bits, including an acknowledge and a return in the same cycle, and they exercise edge latching against level sensing on an external pin.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int NUM_EXT = 2;
  localparam int NUM_PER = NUM_SRC - NUM_EXT;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef logic [IDX_W-1:0] srcIdx_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_EXT-1:0] clrEdge;
    logic               setHigh;
    logic               setLow;
    logic               retire;
  } ctlStrobe_t;

  // Lowest set index of a mask (0 when empty)
  function automatic srcIdx_t firstSet(input logic [NUM_SRC-1:0] m);
    srcIdx_t r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (m[i]) r = srcIdx_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReqN,
  input  logic [NUM_EXT-1:0] extEdgeMode,
  input  logic [NUM_PER-1:0] periphReq,
  input  ctlStrobe_t         strobe,
  input  srcIdx_t            winIdx,
  output logic [NUM_SRC-1:0] srcReq,
  output logic [1:0]         inSvc,
  output logic [VEC_W-1:0]   vector
);
  localparam logic [VEC_W-1:0] BASE_V   = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STRIDE_V = VEC_W'(VEC_STRIDE);

  logic [NUM_EXT-1:0] pinPrevN;
  logic [NUM_EXT-1:0] edgeFlag;

  // Falling-edge capture per external pin; a new edge beats a clear
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_edge
    logic fallSeen;
    assign fallSeen = pinPrevN[k] & ~extReqN[k] & extEdgeMode[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinPrevN[k] <= 1'b1;
        edgeFlag[k] <= 1'b0;
      end else begin
        pinPrevN[k] <= extReqN[k];
        if (fallSeen)               edgeFlag[k] <= 1'b1;
        else if (strobe.clrEdge[k]) edgeFlag[k] <= 1'b0;
      end
    end

    // R9: a latched edge survives until a clear strobe
    assert_edge_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
      (edgeFlag[k] && !strobe.clrEdge[k]) |=> edgeFlag[k]);
  end

  // Source vector assembly: externals at even slots, peripherals fill the rest
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if ((s % 2 == 0) && (s / 2 < NUM_EXT)) begin : g_ext
      assign srcReq[s] = extEdgeMode[s/2] ? edgeFlag[s/2] : ~extReqN[s/2];
    end else begin : g_per
      localparam int EXT_BELOW = ((s + 1) / 2 < NUM_EXT) ? (s + 1) / 2 : NUM_EXT;
      assign srcReq[s] = periphReq[s - EXT_BELOW];
    end
  end

  // In-service level bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvc <= 2'b00;
    end else if (strobe.retire) begin
      if (inSvc[1]) inSvc[1] <= 1'b0;
      else          inSvc[0] <= 1'b0;
    end else if (strobe.setHigh) begin
      inSvc[1] <= 1'b1;
    end else if (strobe.setLow) begin
      inSvc[0] <= 1'b1;
    end
  end

  assign vector = BASE_V + VEC_W'(winIdx) * STRIDE_V;
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcPrioHigh,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [1:0]         inSvc,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               pending,
  output srcIdx_t            winIdx,
  output ctlStrobe_t         strobe
);
  logic [NUM_SRC-1:0] cand, candHigh, candLow, allowHigh, allowLow, winMask;
  logic useHigh, ackTake;

  always_comb begin
    cand      = globalEn ? (srcReq & srcEn) : '0;
    candHigh  = cand & srcPrioHigh;
    candLow   = cand & ~srcPrioHigh;
    allowHigh = inSvc[1] ? '0 : candHigh;
    allowLow  = (inSvc != 2'b00) ? '0 : candLow;
    useHigh   = |allowHigh;
    winMask   = useHigh ? allowHigh : allowLow;
    pending   = |winMask;
    winIdx    = firstSet(winMask);
  end

  assign ackTake = irqAck & ~irqRet & pending;

  always_comb begin
    strobe         = '0;
    strobe.retire  = irqRet;
    strobe.setHigh = ackTake & useHigh;
    strobe.setLow  = ackTake & ~useHigh;
    for (int k = 0; k < NUM_EXT; k++)
      strobe.clrEdge[k] = ackTake && (winIdx == srcIdx_t'(2 * k));
  end

  // R2: global gate
  assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !pending);
  // R7: high level in service blocks everything
  assert_high_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    inSvc[1] |-> !pending);
  // R6: at most one level is set per acknowledge
  assert_one_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setHigh, strobe.setLow}));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcPrioHigh,
  input  logic [NUM_EXT-1:0] extReqN,
  input  logic [NUM_EXT-1:0] extEdgeMode,
  input  logic [NUM_PER-1:0] periphReq,
  input  logic               irqAck,
  input  logic               irqRet,
  output logic               irqPending,
  output logic [VEC_W-1:0]   irqVector,
  output logic [1:0]         inService
);
  ctlStrobe_t         strobe;
  srcIdx_t            winIdx;
  logic [NUM_SRC-1:0] srcReq;

  irq_datapath #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) dp_i (
    .clk(clk), .rstN(rstN), .extReqN(extReqN), .extEdgeMode(extEdgeMode),
    .periphReq(periphReq), .strobe(strobe), .winIdx(winIdx),
    .srcReq(srcReq), .inSvc(inService), .vector(irqVector)
  );

  irq_control ctl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .srcEn(srcEn),
    .srcPrioHigh(srcPrioHigh), .srcReq(srcReq), .inSvc(inService),
    .irqAck(irqAck), .irqRet(irqRet), .pending(irqPending),
    .winIdx(winIdx), .strobe(strobe)
  );

  // R3: vector lands on the fixed grid
  assert_vec_grid_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (int'(irqVector) >= VEC_BASE &&
                    int'(irqVector) <= VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE &&
                    ((int'(irqVector) - VEC_BASE) % VEC_STRIDE) == 0));
  // R6: a taken acknowledge leaves some level in service
  assert_ack_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqRet && irqPending) |=> (inService != 2'b00));
  // R8: return retires the high level first
  assert_ret_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqRet && inService[1]) |=> (!inService[1] && inService[0] == $past(inService[0])));
  assert_ret_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqRet && inService == 2'b01) |=> (inService == 2'b00));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       globalEn;
  logic [5:0] srcEn, srcPrioHigh;
  logic [1:0] extReqN, extEdgeMode;
  logic [3:0] periphReq;
  logic       irqAck, irqRet;
  logic       irqPending;
  logic [15:0] irqVector;
  logic [1:0] inService;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .srcEn(srcEn),
    .srcPrioHigh(srcPrioHigh), .extReqN(extReqN), .extEdgeMode(extEdgeMode),
    .periphReq(periphReq), .irqAck(irqAck), .irqRet(irqRet),
    .irqPending(irqPending), .irqVector(irqVector), .inService(inService)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive a level request mask in source-index order
  task automatic setReq(input logic [5:0] m);
    extReqN   = {~m[2], ~m[0]};
    periphReq = {m[5], m[4], m[3], m[1]};
  endtask

  function automatic void model(input logic [5:0] req, input logic [5:0] en,
                                input logic [5:0] prio, input logic g,
                                input logic [1:0] isv,
                                output logic p, output logic [15:0] v);
    logic [5:0] c, hi, lo, w;
    c  = g ? (req & en) : 6'd0;
    hi = isv[1] ? 6'd0 : (c & prio);
    lo = (isv != 2'b00) ? 6'd0 : (c & ~prio);
    w  = (hi != 0) ? hi : lo;
    p  = (w != 0);
    v  = 16'd3;
    for (int i = 5; i >= 0; i--) if (w[i]) v = 16'(3 + 8 * i);
  endfunction

  task automatic compare(input string tag, input logic [5:0] req, input logic [5:0] en,
                         input logic [5:0] prio, input logic g, input logic [1:0] isv);
    logic ep; logic [15:0] ev;
    model(req, en, prio, g, isv, ep, ev);
    check(irqPending == ep, {tag, " pending"}, int'(irqPending), int'(ep));
    if (ep) check(irqVector == ev, {tag, " vector"}, int'(irqVector), int'(ev));
  endtask

  task automatic pulseAck();
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0; #1;
  endtask
  task automatic pulseRet();
    irqRet = 1'b1; @(negedge clk); irqRet = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; globalEn = 1'b0; srcEn = '0; srcPrioHigh = '0;
    extReqN = 2'b11; extEdgeMode = 2'b00; periphReq = '0;
    irqAck = 1'b0; irqRet = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    // R1: reset state
    check(irqPending == 1'b0, "R1 pending", int'(irqPending), 0);
    check(inService == 2'b00, "R1 inService", int'(inService), 0);

    // R3: single sources, vector grid
    globalEn = 1'b1; srcEn = 6'h3f;
    for (int s = 0; s < 6; s++) begin
      setReq(6'(1 << s)); #1;
      check(irqPending, "R3 single pending", int'(irqPending), 1);
      check(irqVector == 16'(3 + 8 * s), "R3 single vector", int'(irqVector), 3 + 8 * s);
    end

    // R4/R5: requests x priority masks
    for (int r = 0; r < 64; r++) begin
      for (int p = 0; p < 64; p++) begin
        setReq(6'(r)); srcPrioHigh = 6'(p); #1;
        compare("R4 R5 sweep", 6'(r), 6'h3f, 6'(p), 1'b1, 2'b00);
      end
    end

    // R2: requests x enable masks, then global off
    srcPrioHigh = 6'h15;
    for (int r = 0; r < 64; r++) begin
      for (int e = 0; e < 64; e++) begin
        setReq(6'(r)); srcEn = 6'(e); #1;
        compare("R2 enable sweep", 6'(r), 6'(e), 6'h15, 1'b1, 2'b00);
      end
    end
    srcEn = 6'h3f; setReq(6'h3f); globalEn = 1'b0; #1;
    check(!irqPending, "R2 global off", int'(irqPending), 0);
    globalEn = 1'b1;

    // R6/R7/R8: nesting
    @(negedge clk);
    srcPrioHigh = 6'b010000; setReq(6'b000010); #1;
    check(irqPending && irqVector == 16'h000B, "R6 low pending vector", int'(irqVector), 16'h000B);
    pulseAck();
    check(inService == 2'b01, "R6 low ack", int'(inService), 1);
    check(!irqPending, "R7 same level blocked", int'(irqPending), 0);
    setReq(6'b010010); #1;
    check(irqPending && irqVector == 16'h0023, "R7 high preempts", int'(irqVector), 16'h0023);
    pulseAck();
    check(inService == 2'b11, "R6 high ack", int'(inService), 3);
    check(!irqPending, "R7 high blocks all", int'(irqPending), 0);
    pulseRet();
    check(inService == 2'b01, "R8 ret high first", int'(inService), 1);
    check(irqPending, "R7 high pending again", int'(irqPending), 1);
    setReq(6'b000000); #1;
    pulseRet();
    check(inService == 2'b00, "R8 ret low", int'(inService), 0);
    pulseAck();
    check(inService == 2'b00, "R6 ack without pending", int'(inService), 0);
    setReq(6'b010000); #1;
    pulseAck();
    check(inService == 2'b10, "R6 high from idle", int'(inService), 2);
    pulseRet();
    check(inService == 2'b00, "R8 ret from high only", int'(inService), 0);

    // R11: ack and return together
    setReq(6'b000010); #1;
    pulseAck();
    setReq(6'b010000); #1;
    irqAck = 1'b1; irqRet = 1'b1; @(negedge clk); irqAck = 1'b0; irqRet = 1'b0; #1;
    check(inService == 2'b00, "R11 ack ignored with ret", int'(inService), 0);
    setReq(6'b000000);

    // R9: edge latch on external source 0
    srcPrioHigh = 6'b000000; extEdgeMode = 2'b01; #1;
    check(!irqPending, "R9 idle edge mode", int'(irqPending), 0);
    extReqN[0] = 1'b0; @(negedge clk); extReqN[0] = 1'b1; #1;
    check(irqPending && irqVector == 16'h0003, "R9 latched", int'(irqPending), 1);
    @(negedge clk); #1;
    check(irqPending, "R9 held", int'(irqPending), 1);
    pulseAck();
    check(inService == 2'b01, "R9 ack level", int'(inService), 1);
    pulseRet();
    check(!irqPending, "R9 cleared by ack", int'(irqPending), 0);

    // R11 on the latch: ack with ret keeps the flag
    extReqN[0] = 1'b0; @(negedge clk); extReqN[0] = 1'b1; #1;
    irqAck = 1'b1; irqRet = 1'b1; @(negedge clk); irqAck = 1'b0; irqRet = 1'b0; #1;
    check(irqPending, "R11 latch kept", int'(irqPending), 1);
    pulseAck(); pulseRet();

    // R10: level mode is not latched
    extEdgeMode = 2'b00;
    extReqN[1] = 1'b0; #1;
    check(irqPending && irqVector == 16'h0013, "R10 level active", int'(irqVector), 16'h0013);
    @(negedge clk); extReqN[1] = 1'b1; #1;
    check(!irqPending, "R10 not latched", int'(irqPending), 0);
    @(negedge clk); #1;
    check(!irqPending, "R10 still idle", int'(irqPending), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule